// File: doc/BRIEF.md
# Cascadable Priority Interrupt Controller

This block gathers up to eight interrupt request lines, latches them on rising edges, and resolves them by fixed priority, where line 0 is the most urgent. It drives one interrupt output toward the processor. Software programs it through two byte-wide addresses. Address 0 is the command port and address 1 is the data port.

A command-port write with bit 4 set starts a setup sequence. The next three data-port writes are consumed as setup bytes. After that, a data-port write loads the mask. Software acknowledges an interrupt by writing a poll command and then reading the command port. That read returns the winning line and moves it into service. A non-specific end-of-interrupt command ends service for the most urgent in-service line.

Two instances can be chained: the secondary's interrupt output feeds input 2 of the primary. A cascaded interrupt then needs one poll on each instance and one end-of-interrupt on each instance.

Top module: `cascade_pic`

## Requirements
- R1: After reset, `int_o` is low, a data-port read returns the mask as 0xFF (all lines masked), and a command-port read returns the request register as 0x00.
- R2: A command-port write with bit 4 set does the following: clears the mask to 0x00, clears the in-service and request registers, cancels any poll, and selects the request register for command-port reads. The next three data-port writes are consumed as setup bytes and do not load the mask.
- R3: Outside setup, a data-port write loads the mask and a data-port read returns it. A 1 in bit n keeps line n from raising `int_o`, but line n is still latched in the request register.
- R4: A rising edge on `irq_i[n]` sets request bit n. The bit clears if the line falls before acknowledge. Acknowledge clears the bit, and a line that is still held high afterwards does not request again without a new edge.
- R5: A command write of 0x0C arms a poll. The next command-port read returns 0x80 OR the winning line number (bits 2:0), using the lowest-numbered unmasked pending line. If nothing was pending, the read returns 0x00 and the in-service register is unchanged.
- R6: The poll read sets in-service bit n. While a line of equal or higher priority is in service, a lower line cannot raise `int_o`.
- R7: A command write of 0x0B selects the in-service register for later command-port reads, and 0x0A selects the request register. The selection persists across reads.
- R8: A command write of 0x20 clears only the lowest-numbered set in-service bit.
- R9: Line 7 can be asserted at the poll command and withdrawn before the poll read. In that case the read returns 0x87 and in-service bit 7 stays clear.
- R10: A higher-priority request raises `int_o` while a lower line is in service, and it can be acknowledged on top of it, so both lines are then in service.
- R11: With the secondary's `int_o` feeding primary input 2, a secondary request reaches the primary as line 2. A later secondary request cannot interrupt the primary again until the primary has also received end-of-interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe (a command-port read consumes a poll) |
| addr_i | input | 1 | 0 = command port, 1 = data port |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the addressed port |
| irq_i | input | 8 | Interrupt request lines, line 0 most urgent |
| int_o | output | 1 | Interrupt to processor or to a primary input |

## Verification
The checker watches four things on every cycle:
- a request bit never exists without its line having been high on the previous cycle;
- `int_o` is never asserted when no unmasked request is latched;
- in-service bits appear one at a time, and only on a command-port read;
- setup and end-of-interrupt each change state by exactly the expected amount.

Some behaviours depend on a sequence of events, and only the directed scenarios can show them:
- the poll values for priority and nesting;
- the spurious line-7 result;
- the sticky read selection;
- the two-stage end-of-interrupt across a chained pair.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [1:0] {ST_RUN, ST_W2, ST_W3, ST_W4} init_st_e;
endpackage

// File: rtl/pic_req_latch.sv
module pic_req_latch #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] irq_i,
  input  logic [DW-1:0] ack_i,
  input  logic          clr_i,
  output logic [DW-1:0] irr_o
);
  logic [DW-1:0] prev_q, irr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      irr_q  <= '0;
    end else begin
      prev_q <= irq_i;
      if (clr_i) irr_q <= '0;
      else       irr_q <= ((irr_q & irq_i) | (irq_i & ~prev_q)) & ~ack_i;
    end
  end

  assign irr_o = irr_q;
endmodule

// File: rtl/pic_resolver.sv
module pic_resolver #(
  parameter int unsigned DW  = 8,
  localparam int unsigned IDW = $clog2(DW)
) (
  input  logic [DW-1:0]  irr_i,
  input  logic [DW-1:0]  imr_i,
  input  logic [DW-1:0]  isr_i,
  output logic           pend_vld_o,
  output logic [IDW-1:0] pend_id_o,
  output logic           eoi_vld_o,
  output logic [IDW-1:0] eoi_id_o
);
  logic [DW-1:0] req;
  assign req = irr_i & ~imr_i;

  always_comb begin
    logic blocked;
    blocked    = 1'b0;
    pend_vld_o = 1'b0;
    pend_id_o  = '0;
    eoi_vld_o  = 1'b0;
    eoi_id_o   = '0;
    for (int i = 0; i < DW; i++) begin
      if (isr_i[i]) begin
        if (!eoi_vld_o) begin
          eoi_vld_o = 1'b1;
          eoi_id_o  = IDW'(i);
        end
        blocked = 1'b1;
      end
      if (!blocked && !pend_vld_o && req[i]) begin
        pend_vld_o = 1'b1;
        pend_id_o  = IDW'(i);
      end
    end
  end
endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl
  import pic_pkg::*;
#(
  parameter int unsigned DW  = 8,
  localparam int unsigned IDW = $clog2(DW)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_i,
  input  logic           rd_i,
  input  logic           addr_i,
  input  logic [7:0]     wdata_i,
  input  logic [DW-1:0]  irr_i,
  input  logic           pend_vld_i,
  input  logic [IDW-1:0] pend_id_i,
  input  logic           eoi_vld_i,
  input  logic [IDW-1:0] eoi_id_i,
  output logic [DW-1:0]  imr_o,
  output logic [DW-1:0]  isr_o,
  output logic [DW-1:0]  ack_o,
  output logic           init_o,
  output logic [DW-1:0]  rdata_o
);
  init_st_e      st_q;
  logic [DW-1:0] imr_q, isr_q, poll_val;
  logic          sel_isr_q, poll_q, poll_int_q;
  logic          cmd_wr, dat_wr, poll_rd, is_init, is_ocw3, is_eoi;

  assign cmd_wr  = wr_i & ~addr_i;
  assign dat_wr  = wr_i & addr_i;
  assign poll_rd = rd_i & ~addr_i & poll_q;
  assign is_init = wdata_i[4];
  assign is_ocw3 = wdata_i[3] & ~wdata_i[4];
  assign is_eoi  = ~wdata_i[3] & ~wdata_i[4] & (wdata_i[7:5] == 3'b001);
  assign init_o  = cmd_wr & is_init;

  always_comb begin
    ack_o = '0;
    if (poll_rd && pend_vld_i) ack_o[pend_id_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_RUN;
      imr_q      <= '1;
      isr_q      <= '0;
      sel_isr_q  <= 1'b0;
      poll_q     <= 1'b0;
      poll_int_q <= 1'b0;
    end else begin
      if (cmd_wr) begin
        if (is_init) begin
          st_q      <= ST_W2;
          imr_q     <= '0;
          isr_q     <= '0;
          sel_isr_q <= 1'b0;
          poll_q    <= 1'b0;
        end else if (is_ocw3) begin
          if (wdata_i[2]) begin
            poll_q     <= 1'b1;
            poll_int_q <= pend_vld_i;
          end
          if (wdata_i[1]) sel_isr_q <= wdata_i[0];
        end else if (is_eoi && eoi_vld_i) begin
          isr_q[eoi_id_i] <= 1'b0;
        end
      end
      if (dat_wr) begin
        unique case (st_q)
          ST_W2:   st_q <= ST_W3;
          ST_W3:   st_q <= ST_W4;
          ST_W4:   st_q <= ST_RUN;
          default: imr_q <= wdata_i[DW-1:0];
        endcase
      end
      if (poll_rd) begin
        poll_q <= 1'b0;
        if (pend_vld_i) isr_q[pend_id_i] <= 1'b1;
      end
    end
  end

  // spurious report uses the last line number
  always_comb begin
    poll_val = '0;
    if (pend_vld_i || poll_int_q) begin
      poll_val[DW-1]    = 1'b1;
      poll_val[IDW-1:0] = pend_vld_i ? pend_id_i : IDW'(DW-1);
    end
  end

  always_comb begin
    if (addr_i)         rdata_o = imr_q;
    else if (poll_q)    rdata_o = poll_val;
    else if (sel_isr_q) rdata_o = isr_q;
    else                rdata_o = irr_i;
  end

  assign imr_o = imr_q;
  assign isr_o = isr_q;
endmodule

// File: rtl/cascade_pic.sv
module cascade_pic #(
  parameter int unsigned DW = 8,
  localparam int unsigned IDW = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic          addr_i,
  input  logic [7:0]    wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [DW-1:0] irq_i,
  output logic          int_o
);
  logic [DW-1:0]  irr, imr, isr, ack;
  logic           init, pend_vld, eoi_vld;
  logic [IDW-1:0] pend_id, eoi_id;

  pic_req_latch #(.DW(DW)) u_req (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_i(irq_i),
    .ack_i(ack), .clr_i(init), .irr_o(irr)
  );

  pic_resolver #(.DW(DW)) u_res (
    .irr_i(irr), .imr_i(imr), .isr_i(isr),
    .pend_vld_o(pend_vld), .pend_id_o(pend_id),
    .eoi_vld_o(eoi_vld), .eoi_id_o(eoi_id)
  );

  pic_ctrl #(.DW(DW)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .rd_i(rd_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .irr_i(irr),
    .pend_vld_i(pend_vld), .pend_id_i(pend_id),
    .eoi_vld_i(eoi_vld), .eoi_id_i(eoi_id),
    .imr_o(imr), .isr_o(isr), .ack_o(ack), .init_o(init),
    .rdata_o(rdata_o)
  );

  assign int_o = pend_vld;
endmodule

// File: rtl/pic_chk.sv
module pic_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_i,
  input logic          rd_i,
  input logic          addr_i,
  input logic [7:0]    wdata_i,
  input logic [DW-1:0] irq_i,
  input logic          int_o,
  input logic [DW-1:0] irr,
  input logic [DW-1:0] imr,
  input logic [DW-1:0] isr
);
  // R4
  req_needs_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irr & ~$past(irq_i)) == '0);

  // R3
  masked_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((irr & ~imr) == '0) |-> !int_o);

  // R6
  isr_set_on_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((isr & ~$past(isr)) != '0) |-> $past(rd_i && !addr_i));

  // R6
  isr_one_at_a_time_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(isr & ~$past(isr)) <= 1);

  // R2
  init_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !addr_i && wdata_i[4]) |=> (isr == '0 && imr == '0));

  // R8
  eoi_drops_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !rd_i && !addr_i && wdata_i == 8'h20 && isr != '0)
      |=> $countones(isr) == $countones($past(isr)) - 1);
endmodule

bind cascade_pic pic_chk #(.DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .rd_i(rd_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .irq_i(irq_i), .int_o(int_o),
  .irr(irr), .imr(imr), .isr(isr)
);

// File: tb/sim_cascade_pic.sv
`timescale 1ns/1ps
module sim_cascade_pic;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       wr_m = 0, rd_m = 0, wr_s = 0, rd_s = 0, addr = 0;
  logic [7:0] wdata = '0, rdata_m, rdata_s, irq_drv = '0, irq_s = '0, irq_m;
  logic       int_m, int_s;
  int         n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  assign irq_m = {irq_drv[7:3], int_s, irq_drv[1:0]};

  cascade_pic u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr_m), .rd_i(rd_m), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata_m), .irq_i(irq_m), .int_o(int_m)
  );
  cascade_pic u1 (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr_s), .rd_i(rd_s), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata_s), .irq_i(irq_s), .int_o(int_s)
  );

  task automatic chk(input string r, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic bus_wr(input bit sl, input bit a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d;
    if (sl) wr_s = 1; else wr_m = 1;
    @(negedge clk);
    wr_s = 0; wr_m = 0;
  endtask

  task automatic bus_rd(input bit sl, input bit a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    if (sl) rd_s = 1; else rd_m = 1;
    #1 d = sl ? rdata_s : rdata_m;
    @(negedge clk);
    rd_s = 0; rd_m = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(input bit sl, input logic [7:0] cas);
    bus_wr(sl, 0, 8'h11);
    bus_wr(sl, 1, sl ? 8'h08 : 8'h00);
    bus_wr(sl, 1, cas);
    bus_wr(sl, 1, 8'h01);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 int", {7'd0, int_m}, 8'h00);
    bus_rd(0, 1, d); chk("R1 mask", d, 8'hFF);
    bus_rd(0, 0, d); chk("R1 irr", d, 8'h00);
  endtask

  task automatic t_init();
    logic [7:0] d;
    bus_wr(0, 1, 8'h5A);
    setup(0, 8'h04);
    bus_rd(0, 1, d); chk("R2 mask cleared, setup bytes not loaded", d, 8'h00);
    bus_wr(0, 1, 8'h33);
    bus_rd(0, 1, d); chk("R3 mask readback", d, 8'h33);
    bus_wr(0, 1, 8'h00);
    setup(1, 8'h02);
    bus_rd(1, 1, d); chk("R2 secondary mask", d, 8'h00);
  endtask

  task automatic t_mask();
    logic [7:0] d;
    bus_wr(0, 1, 8'h40);
    irq_drv[6] = 1; idle(3);
    chk("R3 masked no int", {7'd0, int_m}, 8'h00);
    bus_rd(0, 0, d); chk("R3 masked still latched", d, 8'h40);
    bus_wr(0, 1, 8'h00); idle(1);
    chk("R3 unmask raises int", {7'd0, int_m}, 8'h01);
    bus_wr(0, 0, 8'h0C);
    bus_rd(0, 0, d); chk("R5 poll line 6", d, 8'h86);
    irq_drv[6] = 0;
    bus_wr(0, 0, 8'h20);
  endtask

  task automatic t_prio();
    logic [7:0] d;
    irq_drv[3] = 1; irq_drv[5] = 1; idle(3);
    bus_wr(0, 0, 8'h0C);
    bus_rd(0, 0, d); chk("R5 lowest number wins", d, 8'h83);
    idle(1);
    chk("R6 lower blocked while 3 in service", {7'd0, int_m}, 8'h00);
    bus_wr(0, 0, 8'h0A);
    bus_rd(0, 0, d); chk("R4 held line not re-requested", d, 8'h20);
    bus_wr(0, 0, 8'h20); idle(1);
    chk("R6 int after eoi", {7'd0, int_m}, 8'h01);
    bus_wr(0, 0, 8'h0C);
    bus_rd(0, 0, d); chk("R5 next line 5", d, 8'h85);
    bus_wr(0, 0, 8'h20);
    irq_drv[3] = 0; irq_drv[5] = 0; idle(2);
    bus_wr(0, 0, 8'h0C);
    bus_rd(0, 0, d); chk("R5 empty poll", d, 8'h00);
    bus_wr(0, 0, 8'h0B);
    bus_rd(0, 0, d); chk("R5 empty poll leaves isr", d, 8'h00);
  endtask

  task automatic t_nest();
    logic [7:0] d;
    irq_drv[4] = 1; idle(3);
    bus_wr(0, 0, 8'h0C);
    bus_rd(0, 0, d); chk("R5 poll line 4", d, 8'h84);
    irq_drv[1] = 1; idle(3);
    chk("R10 higher interrupts", {7'd0, int_m}, 8'h01);
    bus_wr(0, 0, 8'h0C);
    bus_rd(0, 0, d); chk("R10 poll line 1", d, 8'h81);
    bus_wr(0, 0, 8'h0B);
    bus_rd(0, 0, d); chk("R10 both in service", d, 8'h12);
    bus_rd(0, 0, d); chk("R7 isr select sticky", d, 8'h12);
    bus_wr(0, 0, 8'h20);
    bus_rd(0, 0, d); chk("R8 eoi clears bit 1 only", d, 8'h10);
    bus_wr(0, 0, 8'h20);
    bus_rd(0, 0, d); chk("R8 second eoi", d, 8'h00);
    irq_drv[1] = 0; irq_drv[4] = 0; idle(2);
  endtask

  task automatic t_drop();
    logic [7:0] d;
    irq_drv[6] = 1; idle(2);
    irq_drv[6] = 0; idle(2);
    bus_wr(0, 0, 8'h0A);
    bus_rd(0, 0, d); chk("R4 withdrawn request cleared", d, 8'h00);
    chk("R4 no int", {7'd0, int_m}, 8'h00);
  endtask

  task automatic t_spur();
    logic [7:0] d;
    irq_drv[7] = 1; idle(3);
    bus_wr(0, 0, 8'h0C);
    irq_drv[7] = 0; idle(2);
    bus_rd(0, 0, d); chk("R9 spurious reports 7", d, 8'h87);
    bus_wr(0, 0, 8'h0B);
    bus_rd(0, 0, d); chk("R9 isr bit 7 clear", d, 8'h00);
  endtask

  task automatic t_cascade();
    logic [7:0] d;
    irq_s[3] = 1; idle(4);
    chk("R11 reaches primary", {7'd0, int_m}, 8'h01);
    bus_wr(0, 0, 8'h0C);
    bus_rd(0, 0, d); chk("R11 primary sees line 2", d, 8'h82);
    bus_wr(1, 0, 8'h0C);
    bus_rd(1, 0, d); chk("R11 secondary line 3", d, 8'h83);
    idle(1);
    chk("R11 int drops after acks", {7'd0, int_m}, 8'h00);
    bus_wr(1, 0, 8'h20);
    irq_s[5] = 1; idle(4);
    chk("R11 secondary raises again", {7'd0, int_s}, 8'h01);
    chk("R11 primary holds until its eoi", {7'd0, int_m}, 8'h00);
    bus_wr(0, 0, 8'h20); idle(1);
    chk("R11 primary after eoi", {7'd0, int_m}, 8'h01);
    bus_wr(0, 0, 8'h0C);
    bus_rd(0, 0, d); chk("R11 primary line 2 again", d, 8'h82);
    bus_wr(1, 0, 8'h0C);
    bus_rd(1, 0, d); chk("R11 secondary line 5", d, 8'h85);
    bus_wr(1, 0, 8'h20);
    bus_wr(0, 0, 8'h20);
    bus_wr(1, 0, 8'h0B);
    bus_rd(1, 0, d); chk("R11 secondary isr empty", d, 8'h00);
    bus_wr(0, 0, 8'h0B);
    bus_rd(0, 0, d); chk("R11 primary isr empty", d, 8'h00);
    irq_s = '0; idle(2);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_init();
    t_mask();
    t_prio();
    t_nest();
    t_drop();
    t_spur();
    t_cascade();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule